// File: doc/BRIEF.md
# Cycle and Event Performance Counter Unit

This block is a performance monitoring unit with a small register bus. It holds one 32-bit cycle counter and four programmable 32-bit event counters. Each event counter picks one line of an event bus with its own select register. The event bus carries single-cycle pulses from sources such as cache-miss, branch-prediction or instruction-retire logic. A global enable in the control register gates every counter. Separate write-one-to-set and write-one-to-clear registers switch the individual counters on and off.

The cycle counter can run at the full clock rate or in a divide-by-64 mode. A wrap from all ones to zero sets a sticky overflow flag for that counter. The interrupt output is raised while any flag is set and its interrupt-enable bit is also set. Software writes 1 to a flag to clear it. Privileged masters always have access. Unprivileged masters have access only after a privileged master sets the user-access bit.

Each bus access is one request cycle. The response follows one clock later and carries the read data and an access-error flag.

Top module: `perf_mon_unit`

## Requirements
- R1: While the global enable and the cycle-counter enable are both set, and prescale mode is off, the cycle counter advances by one on every clock. A read at request edge k returns the value held before edge k.
- R2: When control bit 3 is set, the cycle counter advances once every 64 counting clocks. A 6-bit prescaler produces this rate. Its first tick comes 64 counting clocks after it is cleared. The prescaler clears when the cycle counter is reset or when bit 3 changes value.
- R3: Event counter i (i = 0..3) advances by one on each clock in which both of these hold: its enable bit is set, and the event line named by its select register (word 12+i, low 3 bits) is high. Pulses on lines it does not select do nothing.
- R4: While control bit 0 (global enable) is clear, no counter advances. Writes to counter data registers still load the written value.
- R5: A write to the enable-set register (word 1) sets each enable whose data bit is 1. A write to the enable-clear register (word 2) clears each enable whose data bit is 1. Zero bits leave enables unchanged. Bit 31 is the cycle counter and bits 0..3 are event counters 0..3. Reading either register returns the current enable mask.
- R6: Control register (word 0) layout: bit 0 is the global enable, bit 1 is a self-clearing reset of all event counters, bit 2 is a self-clearing reset of the cycle counter, and bit 3 is prescale mode. Reading the register returns only bits 0 and 3. Writing 5 sets the global enable and restarts the cycle counter from zero in the same write.
- R7: A counter that wraps from all ones to zero sets its sticky overflow flag. The flags are in word 3, with bit 31 for the cycle counter and bits 0..3 for the event counters. Writing 1 to a flag clears it. Writing 0 leaves it unchanged.
- R8: `irq` is high one clock after any overflow flag and its matching bit in the interrupt-enable register (word 4, same bit layout) are both set. `irq` stays low while every set flag is masked.
- R9: Bit 0 of word 5 is the user-access bit. If it is clear, an unprivileged access changes no state, reads zero and raises `access_err` in its response cycle. An unprivileged write to word 5 is always rejected in the same way. When the bit is set, unprivileged access to every other register is accepted.
- R10: Each request produces `rsp_valid` exactly one clock later. Write responses carry zero data. The cycle counter is word 6 and event counters are words 8..11. After reset all registers and counters read zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register word address |
| req_wdata | input | 32 | Write data |
| req_priv | input | 1 | Request comes from a privileged master |
| evt_in | input | 8 | Event pulse bus |
| rsp_valid | output | 1 | Response cycle for the previous request |
| rsp_rdata | output | 32 | Read data (zero for writes and rejected accesses) |
| access_err | output | 1 | The previous request was rejected |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench builds the unit with its defaults: 32-bit counters, four event counters, an 8-line event bus and a 6-bit prescaler. With full-width counters, overflow can only be reached by loading a value one or two steps below all ones and then letting the counter wrap. The 64-clock prescale period is short enough that the bench can observe two consecutive prescaled steps at exact cycle positions within about 130 clocks. The 8-line bus lets the bench drive selected and unselected event lines side by side and confirm that only the selected pulses are counted.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned DW     = 32;

  localparam logic [REG_AW-1:0] A_CTRL  = 4'd0;
  localparam logic [REG_AW-1:0] A_ENSET = 4'd1;
  localparam logic [REG_AW-1:0] A_ENCLR = 4'd2;
  localparam logic [REG_AW-1:0] A_OVF   = 4'd3;
  localparam logic [REG_AW-1:0] A_IRQEN = 4'd4;
  localparam logic [REG_AW-1:0] A_USER  = 4'd5;
  localparam logic [REG_AW-1:0] A_CYC   = 4'd6;

  localparam int unsigned EVT_CNT_BASE = 8;
  localparam int unsigned EVT_SEL_BASE = 12;
  localparam int unsigned MAX_EVT      = 4;

  localparam int unsigned CTRL_EN    = 0;
  localparam int unsigned CTRL_EVRST = 1;
  localparam int unsigned CTRL_CYRST = 2;
  localparam int unsigned CTRL_PSC   = 3;
  localparam int unsigned CYC_BIT    = 31;
endpackage

// File: rtl/pmu_cnt_slice.sv
module pmu_cnt_slice #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = inc & ~clr & ~load & (&cnt);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  // R4: with no step, load or reset the value holds
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && !inc) |=> (cnt == $past(cnt)));
  // R7: a wrap leaves the counter at zero
  assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int unsigned LOG2 = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic tick
);
  logic [LOG2-1:0] div_q;

  assign tick = adv & ~clr & (&div_q);

  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else if (adv)   div_q <= div_q + 1'b1;
  end

  // R2: two ticks never come on adjacent clocks
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/pmu_regif.sv
module pmu_regif
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [REG_AW-1:0] req_addr,
  input  logic              req_priv,
  input  logic              user_en,
  input  logic [DW-1:0]     rd_word,
  output logic              wr_ok,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              access_err
);
  logic acc_ok;
  logic user_wr;

  assign user_wr = req_write & (req_addr == A_USER);
  assign acc_ok  = req_valid & (req_priv | (user_en & ~user_wr));
  assign wr_ok   = acc_ok & req_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      access_err <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      access_err <= req_valid & ~acc_ok;
      rsp_rdata  <= (acc_ok & ~req_write) ? rd_word : '0;
    end
  end

  // R10: one response per request, one clock later
  assert_rsp_follow_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R9: unprivileged access without the user bit is rejected and reads zero
  assert_reject_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_priv && !user_en) |=> (access_err && rsp_rdata == '0));
  // R9: an unprivileged write to the user-access register is never accepted
  assert_user_lock_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !req_priv && req_addr == A_USER) |=> access_err);
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned N_EVT    = 4,
  parameter int unsigned EVT_BUS  = 8,
  parameter int unsigned PSC_LOG2 = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [3:0]         req_addr,
  input  logic [31:0]        req_wdata,
  input  logic               req_priv,
  input  logic [EVT_BUS-1:0] evt_in,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               access_err,
  output logic               irq
);
  localparam int unsigned SEL_W = (EVT_BUS > 1) ? $clog2(EVT_BUS) : 1;

  logic             wr_ok;
  logic             ctrl_en, psc_mode, user_en;
  logic             cyc_en, ie_cyc, flag_cyc;
  logic [N_EVT-1:0] evt_en, ie_evt, flag_evt;
  logic [SEL_W-1:0] sel_q [N_EVT];
  logic [CNT_W-1:0] cyc_cnt;
  logic [CNT_W-1:0] evt_cnt [N_EVT];
  logic [N_EVT-1:0] evt_wrap, evt_inc, w_evt, w_sel;
  logic             cyc_wrap, cyc_inc, psc_tick;
  logic [DW-1:0]    rd_word, en_word, ovf_word, ie_word;

  // write decode
  logic w_ctrl, w_set, w_clr, w_ovf, w_ie, w_user, w_cyc;
  logic cyc_clr, evt_clr, mode_chg;

  assign w_ctrl   = wr_ok & (req_addr == A_CTRL);
  assign w_set    = wr_ok & (req_addr == A_ENSET);
  assign w_clr    = wr_ok & (req_addr == A_ENCLR);
  assign w_ovf    = wr_ok & (req_addr == A_OVF);
  assign w_ie     = wr_ok & (req_addr == A_IRQEN);
  assign w_user   = wr_ok & (req_addr == A_USER);
  assign w_cyc    = wr_ok & (req_addr == A_CYC);
  assign cyc_clr  = w_ctrl & req_wdata[CTRL_CYRST];
  assign evt_clr  = w_ctrl & req_wdata[CTRL_EVRST];
  assign mode_chg = w_ctrl & (req_wdata[CTRL_PSC] != psc_mode);

  // bus front end
  pmu_regif u_regif (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_priv   (req_priv),
    .user_en    (user_en),
    .rd_word    (rd_word),
    .wr_ok      (wr_ok),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .access_err (access_err)
  );

  // control, enables, interrupt mask, user access
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en  <= 1'b0;
      psc_mode <= 1'b0;
      user_en  <= 1'b0;
      cyc_en   <= 1'b0;
      evt_en   <= '0;
      ie_cyc   <= 1'b0;
      ie_evt   <= '0;
    end else begin
      if (w_ctrl) begin
        ctrl_en  <= req_wdata[CTRL_EN];
        psc_mode <= req_wdata[CTRL_PSC];
      end
      if (w_user) user_en <= req_wdata[0];
      if (w_set) begin
        cyc_en <= cyc_en | req_wdata[CYC_BIT];
        evt_en <= evt_en | req_wdata[N_EVT-1:0];
      end
      if (w_clr) begin
        cyc_en <= cyc_en & ~req_wdata[CYC_BIT];
        evt_en <= evt_en & ~req_wdata[N_EVT-1:0];
      end
      if (w_ie) begin
        ie_cyc <= req_wdata[CYC_BIT];
        ie_evt <= req_wdata[N_EVT-1:0];
      end
    end
  end

  // cycle counter path
  pmu_prescaler #(.LOG2(PSC_LOG2)) u_psc (
    .clk  (clk),
    .rst  (rst),
    .clr  (cyc_clr | mode_chg),
    .adv  (ctrl_en & cyc_en & psc_mode),
    .tick (psc_tick)
  );

  assign cyc_inc = ctrl_en & cyc_en & (psc_mode ? psc_tick : 1'b1);

  pmu_cnt_slice #(.W(CNT_W)) u_cyc (
    .clk      (clk),
    .rst      (rst),
    .clr      (cyc_clr),
    .load     (w_cyc),
    .load_val (req_wdata[CNT_W-1:0]),
    .inc      (cyc_inc),
    .cnt      (cyc_cnt),
    .wrap     (cyc_wrap)
  );

  // event counters
  for (genvar gi = 0; gi < N_EVT; gi++) begin : g_evt
    assign w_evt[gi] = wr_ok & (req_addr == REG_AW'(EVT_CNT_BASE + gi));
    assign w_sel[gi] = wr_ok & (req_addr == REG_AW'(EVT_SEL_BASE + gi));
    assign evt_inc[gi] = ctrl_en & evt_en[gi] &
                         ((32'(sel_q[gi]) < EVT_BUS) ? evt_in[sel_q[gi]] : 1'b0);

    always_ff @(posedge clk) begin
      if (rst)            sel_q[gi] <= '0;
      else if (w_sel[gi]) sel_q[gi] <= req_wdata[SEL_W-1:0];
    end

    pmu_cnt_slice #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .clr      (evt_clr),
      .load     (w_evt[gi]),
      .load_val (req_wdata[CNT_W-1:0]),
      .inc      (evt_inc[gi]),
      .cnt      (evt_cnt[gi]),
      .wrap     (evt_wrap[gi])
    );
  end

  // sticky overflow flags and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_cyc <= 1'b0;
      flag_evt <= '0;
      irq      <= 1'b0;
    end else begin
      flag_cyc <= cyc_wrap | (flag_cyc & ~(w_ovf & req_wdata[CYC_BIT]));
      flag_evt <= evt_wrap | (flag_evt & ~({N_EVT{w_ovf}} & req_wdata[N_EVT-1:0]));
      irq      <= |(ovf_word & ie_word);
    end
  end

  // read views
  always_comb begin
    en_word  = '0;
    ovf_word = '0;
    ie_word  = '0;
    en_word[CYC_BIT]    = cyc_en;
    en_word[N_EVT-1:0]  = evt_en;
    ovf_word[CYC_BIT]   = flag_cyc;
    ovf_word[N_EVT-1:0] = flag_evt;
    ie_word[CYC_BIT]    = ie_cyc;
    ie_word[N_EVT-1:0]  = ie_evt;
  end

  always_comb begin
    rd_word = '0;
    case (req_addr)
      A_CTRL: begin
        rd_word[CTRL_EN]  = ctrl_en;
        rd_word[CTRL_PSC] = psc_mode;
      end
      A_ENSET, A_ENCLR: rd_word = en_word;
      A_OVF:            rd_word = ovf_word;
      A_IRQEN:          rd_word = ie_word;
      A_USER:           rd_word[0] = user_en;
      A_CYC:            rd_word[CNT_W-1:0] = cyc_cnt;
      default:          ;
    endcase
    for (int i = 0; i < N_EVT; i++) begin
      if (req_addr == REG_AW'(EVT_CNT_BASE + i)) rd_word[CNT_W-1:0] = evt_cnt[i];
      if (req_addr == REG_AW'(EVT_SEL_BASE + i)) rd_word[SEL_W-1:0] = sel_q[i];
    end
  end

  // R4: global enable clear freezes the cycle counter unless software writes it
  assert_freeze_R4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !w_cyc && !cyc_clr) |=> $stable(cyc_cnt));
  // R6: writing 5 enables and restarts the cycle counter together
  assert_ctrl_five_R6: assert property (@(posedge clk) disable iff (rst)
    (w_ctrl && req_wdata[2:0] == 3'b101) |=> (ctrl_en && cyc_cnt == '0));
  // R7: the cycle flag stays until written with a 1
  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_cyc && !(w_ovf && req_wdata[CYC_BIT])) |=> flag_cyc);
  // R8: an enabled flag raises the interrupt on the next clock
  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (rst)
    (|(ovf_word & ie_word)) |=> irq);
endmodule

// File: tb/perf_mon_unit_tb.sv
module perf_mon_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  evt_in = '0;
  logic        rsp_valid, access_err, irq;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] exp_d[$];
  logic        exp_e[$];
  string       exp_t[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_mon_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_priv(req_priv),
    .evt_in(evt_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .access_err(access_err), .irq(irq)
  );

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (exp_d.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected response rdata=%h exp=none", rsp_rdata);
      end else begin
        logic [31:0] d;
        logic        e;
        string       t;
        d = exp_d.pop_front();
        e = exp_e.pop_front();
        t = exp_t.pop_front();
        if (rsp_rdata !== d || access_err !== e) begin
          errors++;
          $display("FAIL %s rdata=%h exp=%h err=%b exp=%b", t, rsp_rdata, d, access_err, e);
        end
      end
    end
  end

  // driver
  task automatic acc(input bit wr, input logic [3:0] a, input logic [31:0] d,
                     input bit priv, input logic [31:0] ed, input bit ee, input string t);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_priv = priv;
    exp_d.push_back(ed); exp_e.push_back(ee); exp_t.push_back(t);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr_p(input logic [3:0] a, input logic [31:0] d, input string t);
    acc(1'b1, a, d, 1'b1, 32'h0, 1'b0, t);
  endtask
  task automatic rd_p(input logic [3:0] a, input logic [31:0] ed, input string t);
    acc(1'b0, a, 32'h0, 1'b1, ed, 1'b0, t);
  endtask
  task automatic wr_u(input logic [3:0] a, input logic [31:0] d, input bit ee, input string t);
    acc(1'b1, a, d, 1'b0, 32'h0, ee, t);
  endtask
  task automatic rd_u(input logic [3:0] a, input logic [31:0] ed, input bit ee, input string t);
    acc(1'b0, a, 32'h0, 1'b0, ed, ee, t);
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse(input logic [7:0] m);
    evt_in = m;
    @(negedge clk);
    evt_in = '0;
  endtask
  task automatic chk(input bit act, input bit expv, input string t);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", t, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    chk(irq, 1'b0, "R10 irq after reset");
    rd_p(4'd0, 32'h0, "R10 ctrl reset");
    rd_p(4'd1, 32'h0, "R10 enable reset");
    rd_p(4'd3, 32'h0, "R10 flags reset");
    rd_p(4'd6, 32'h0, "R10 cycle reset");
    rd_p(4'd5, 32'h0, "R10 user reset");

    // R4 load while globally disabled, no counting
    wr_p(4'd6, 32'd1000, "R4 load cycle");
    wr_p(4'd1, 32'h8000_0000, "R5 set cycle enable");
    idle(5);
    rd_p(4'd6, 32'd1000, "R4 frozen while global off");
    rd_p(4'd1, 32'h8000_0000, "R5 set reads mask");

    // R6 write 5 then R1 full rate counting
    wr_p(4'd0, 32'd5, "R6 ctrl write 5");
    rd_p(4'd0, 32'h1, "R6 ctrl reads bits 0 and 3 only");
    rd_p(4'd6, 32'd1, "R6 cycle restarted");
    idle(10);
    rd_p(4'd6, 32'd12, "R1 counts every clock");
    wr_p(4'd2, 32'h0, "R5 clear zero bits");
    rd_p(4'd2, 32'h8000_0000, "R5 clear reads mask unchanged");
    wr_p(4'd2, 32'h8000_0000, "R5 clear cycle enable");
    rd_p(4'd6, 32'd16, "R1 last count before disable");
    idle(3);
    rd_p(4'd6, 32'd16, "R5 disabled cycle holds");
    rd_p(4'd1, 32'h0, "R5 mask empty");

    // R2 prescale by 64
    wr_p(4'd0, 32'hD, "R2 ctrl enable reset prescale");
    wr_p(4'd1, 32'h8000_0000, "R2 enable cycle");
    idle(63);
    rd_p(4'd6, 32'd0, "R2 no step before 64 clocks");
    idle(62);
    rd_p(4'd6, 32'd1, "R2 first prescaled step");
    rd_p(4'd6, 32'd1, "R2 no step at clock 127");
    rd_p(4'd6, 32'd2, "R2 second prescaled step");
    rd_p(4'd0, 32'h9, "R6 ctrl reads prescale bit");
    wr_p(4'd2, 32'h8000_0000, "R2 stop cycle");
    wr_p(4'd0, 32'h1, "R2 prescale off");
    rd_p(4'd6, 32'd2, "R2 value kept");

    // R4 global off with cycle enabled
    wr_p(4'd0, 32'h0, "R4 global off");
    wr_p(4'd1, 32'h8000_0000, "R4 cycle enable on");
    idle(5);
    rd_p(4'd6, 32'd2, "R4 cycle frozen with enable set");

    // R3 event selection
    wr_p(4'd12, 32'd2, "R3 sel0");
    wr_p(4'd13, 32'd5, "R3 sel1");
    wr_p(4'd14, 32'd3, "R3 sel2");
    wr_p(4'd15, 32'd2, "R3 sel3");
    wr_p(4'd1, 32'hB, "R3 enable counters 0 1 3");
    wr_p(4'd0, 32'h1, "R3 global on");
    pulse(8'h04); pulse(8'h04); pulse(8'h08); pulse(8'h20);
    pulse(8'h04); pulse(8'h08); pulse(8'h08); pulse(8'h08);
    rd_p(4'd8,  32'd3, "R3 counter0 line 2");
    rd_p(4'd9,  32'd1, "R3 counter1 line 5");
    rd_p(4'd10, 32'd0, "R3 counter2 disabled");
    rd_p(4'd11, 32'd3, "R3 counter3 line 2");
    rd_p(4'd13, 32'd5, "R3 select readback");
    wr_p(4'd0, 32'h0, "R4 global off");
    pulse(8'h04); pulse(8'h04);
    rd_p(4'd8, 32'd3, "R4 events ignored while off");

    // R6 event reset
    wr_p(4'd0, 32'h2, "R6 event reset");
    rd_p(4'd11, 32'd0, "R6 counter3 cleared");
    rd_p(4'd8,  32'd0, "R6 counter0 cleared");

    // R7 R8 event overflow
    wr_p(4'd4, 32'h1, "R8 irq enable counter0");
    wr_p(4'd8, 32'hFFFF_FFFE, "R7 preload counter0");
    wr_p(4'd0, 32'h1, "R7 global on");
    pulse(8'h04); pulse(8'h04);
    idle(2);
    chk(irq, 1'b1, "R8 irq on enabled flag");
    rd_p(4'd3, 32'h1, "R7 counter0 flag set");
    rd_p(4'd8, 32'h0, "R7 counter0 wrapped");
    wr_p(4'd3, 32'h0, "R7 write zero to flags");
    rd_p(4'd3, 32'h1, "R7 flag kept after zero write");
    wr_p(4'd3, 32'h1, "R7 clear flag");
    idle(2);
    rd_p(4'd3, 32'h0, "R7 flag cleared");
    chk(irq, 1'b0, "R8 irq drops after clear");

    // R7 cycle overflow, masked interrupt
    wr_p(4'd6, 32'hFFFF_FFFF, "R7 preload cycle");
    wr_p(4'd0, 32'h0, "R7 stop after wrap");
    idle(1);
    rd_p(4'd3, 32'h8000_0000, "R7 cycle flag bit 31");
    rd_p(4'd6, 32'h0, "R7 cycle wrapped");
    chk(irq, 1'b0, "R8 masked flag keeps irq low");

    // R9 user access
    wr_p(4'd6, 32'h77, "R9 preload");
    rd_u(4'd6, 32'h0, 1'b1, "R9 unpriv read rejected");
    wr_u(4'd6, 32'h1234, 1'b1, "R9 unpriv write rejected");
    rd_p(4'd6, 32'h77, "R9 state unchanged");
    wr_p(4'd5, 32'h1, "R9 grant user access");
    wr_u(4'd6, 32'h55, 1'b0, "R9 unpriv write accepted");
    rd_u(4'd6, 32'h55, 1'b0, "R9 unpriv read accepted");
    wr_u(4'd5, 32'h0, 1'b1, "R9 unpriv user write rejected");
    rd_u(4'd5, 32'h1, 1'b0, "R9 user bit kept");

    idle(3);
    checks++;
    if (exp_d.size() != 0) begin
      errors++;
      $display("FAIL R10 missing responses actual=%0d expected=0", exp_d.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule